// File: doc/BRIEF.md
# Stack Call/Return Sequencer

This block carries out the four stack-manipulating operations of a small processor: push a register, pop into a register, call a subroutine and return from one. The decoder presents the operation with the current stack-pointer value, the source register value, the call target and the address of the following instruction. The sequencer then makes exactly one word access to data memory and reports the result of the operation for one cycle. That result is the updated stack pointer, a register write-back for pop, and a new program counter for call and return.

The stack grows toward lower addresses, and the stack pointer always addresses the top word. Pushes (push, call) decrement the pointer first and then store at the new address. Pops (pop, return) read at the current address and then increment the pointer. The step is one word of `WORD_BYTES` bytes. If memory answers with an error, the operation is aborted: no state update is requested and the bad-address status code is reported. The general register file, instruction fetch and ALU sit outside this block.

Top module: `stack_seq`

## Requirements
- R1: After reset the block is idle: `mem_req`, `done`, `sp_we`, `rf_we` and `pc_we` are all low.
- R2: Push (`op` = 2'b00) writes `src_val` to memory at `sp_cur - 4` and reports `sp_new = sp_cur - 4` with `sp_we` high and no register or PC write.
- R3: Pop (`op` = 2'b01) reads the word at `sp_cur`, writes it to register `dst_id` through `rf_we`/`rf_id`/`rf_data`, and reports `sp_new = sp_cur + 4`.
- R4: Call (`op` = 2'b10) writes `ret_pc` to memory at `sp_cur - 4`, reports `sp_new = sp_cur - 4` and sets `pc_new = dest_pc` with `pc_we` high.
- R5: Return (`op` = 2'b11) reads the word at `sp_cur`, reports it as `pc_new` with `pc_we` high, and reports `sp_new = sp_cur + 4`.
- R6: A pop whose destination is the stack-pointer register (ID 4) reports the loaded word as `sp_new`, which takes priority over the increment, and raises no `rf_we`.
- R7: A pop whose destination is ID 4'hF ("no register") raises no `rf_we` but still reports `sp_new = sp_cur + 4`.
- R8: A successful operation reports `stat` = 1. An operation whose memory access ends with `mem_err` reports `stat` = 3, keeps `sp_we`, `pc_we` and `rf_we` low, and so leaves the stack pointer and PC unchanged.
- R9: Each operation makes exactly one memory transaction, with `mem_req` and `mem_addr` held until `mem_ack` or `mem_err`, and ends with a `done` pulse one cycle wide.
- R10: A `start` raised while an operation is in progress is ignored: it adds no memory transaction and does not alter the result of the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a stack operation (taken only when idle) |
| op | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| dst_id | input | RID_W | Destination register ID for pop |
| src_val | input | DW | Register value to push |
| sp_cur | input | DW | Current stack-pointer value |
| dest_pc | input | DW | Call target |
| ret_pc | input | DW | Address of the following instruction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | DW | Word address of the access |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access finished successfully |
| mem_err | input | 1 | Access failed (bad address) |
| done | output | 1 | One-cycle completion pulse; results valid |
| stat | output | 3 | 1 = ok, 3 = bad address |
| sp_we | output | 1 | Stack pointer update request |
| sp_new | output | DW | New stack-pointer value |
| rf_we | output | 1 | Register write-back request (pop) |
| rf_id | output | RID_W | Register written back |
| rf_data | output | DW | Value written back |
| pc_we | output | 1 | Program counter update (call, return) |
| pc_new | output | DW | New program counter |

## Verification
The bench builds the block with its defaults: 32-bit words, a 4-byte step, 4-bit register IDs, ID 4 for the stack pointer and 4'hF for "no register". With these values the two priority corners of pop (destination is the stack pointer, destination is "no register") can be reached. So can the round trips push then pop and call then return on the same stack slot. The bench memory model returns an error for any address at or above 0x100. This lets both a failing write (push) and a failing read (return) be driven, and their effect on the state updates be checked.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter int DW = 32,
  parameter int RID_W = 4,
  parameter int WORD_BYTES = 4,
  parameter logic [RID_W-1:0] SP_ID = 4,
  parameter logic [RID_W-1:0] NONE_ID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [RID_W-1:0] dst_id,
  input  logic [DW-1:0]    src_val,
  input  logic [DW-1:0]    sp_cur,
  input  logic [DW-1:0]    dest_pc,
  input  logic [DW-1:0]    ret_pc,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  output logic             done,
  output logic [2:0]       stat,
  output logic             sp_we,
  output logic [DW-1:0]    sp_new,
  output logic             rf_we,
  output logic [RID_W-1:0] rf_id,
  output logic [DW-1:0]    rf_data,
  output logic             pc_we,
  output logic [DW-1:0]    pc_new
);
  localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);
  localparam logic [1:0] OP_POP = 2'b01;
  localparam logic [2:0] ST_OK = 3'd1;
  localparam logic [2:0] ST_ADR = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_FIN} state_t;
  state_t state;

  logic [1:0]       op_q;
  logic [RID_W-1:0] dst_q;
  logic [DW-1:0]    sp_q, tgt_q, data_q;
  logic             err_q;

  logic down, ok, pop_to_sp;
  assign down      = ~op_q[0];
  assign ok        = done & ~err_q;
  assign pop_to_sp = (op_q == OP_POP) && (dst_q == SP_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= '0;
      dst_q  <= '0;
      sp_q   <= '0;
      tgt_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op_q   <= op;
          dst_q  <= dst_id;
          sp_q   <= sp_cur;
          tgt_q  <= dest_pc;
          data_q <= (op == 2'b10) ? ret_pc : src_val;
          err_q  <= 1'b0;
          state  <= S_MEM;
        end
        S_MEM: if (mem_ack || mem_err) begin
          err_q <= mem_err;
          if (!down) data_q <= mem_rdata;
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (state == S_MEM);
  assign mem_we    = mem_req & down;
  assign mem_addr  = down ? sp_q - STEP : sp_q;
  assign mem_wdata = data_q;

  assign done    = (state == S_FIN);
  assign stat    = err_q ? ST_ADR : ST_OK;
  assign sp_we   = ok;
  assign sp_new  = pop_to_sp ? data_q : (down ? sp_q - STEP : sp_q + STEP);
  assign rf_we   = ok && (op_q == OP_POP) && (dst_q != SP_ID) && (dst_q != NONE_ID);
  assign rf_id   = dst_q;
  assign rf_data = data_q;
  assign pc_we   = ok & op_q[1];
  assign pc_new  = op_q[0] ? data_q : tgt_q;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));
  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start && op == 2'b00) |=> (mem_we && mem_addr == $past(sp_cur) - STEP));
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stat == ST_ADR) |-> !(sp_we || pc_we || rf_we));
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> $stable(mem_wdata));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !(sp_we || pc_we || rf_we || mem_req));
endmodule

// File: tb/stack_seq_bench.sv
module stack_seq_bench;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0;
  logic [1:0] op = 0;
  logic [3:0] dst_id = 0;
  logic [31:0] src_val = 0, sp_cur = 0, dest_pc = 0, ret_pc = 0;
  logic mem_req, mem_we, done, sp_we, rf_we, pc_we;
  logic [31:0] mem_addr, mem_wdata, sp_new, rf_data, pc_new;
  logic [31:0] mem_rdata = 0;
  logic mem_ack = 0, mem_err = 0;
  logic [2:0] stat;
  logic [3:0] rf_id;

  stack_seq u_stack_seq (.*);

  logic [31:0] mem [0:63];
  int txn = 0, n_done = 0;
  always_ff @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (mem_req && !mem_ack && !mem_err) begin
      if (mem_addr[31:8] != 0) mem_err <= 1'b1;
      else begin
        mem_ack <= 1'b1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:2]];
      end
    end
    if (mem_ack || mem_err) txn <= txn + 1;
    if (done) n_done <= n_done + 1;
  end

  int checks = 0, fails = 0;
  logic c_sp_we, c_rf_we, c_pc_we;
  logic [31:0] c_sp, c_rf, c_pc;
  logic [2:0] c_stat;
  logic [3:0] c_id;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(logic [1:0] o, logic [3:0] d, logic [31:0] s, logic [31:0] sp,
                        logic [31:0] t, logic [31:0] n, bit second = 0);
    bit seen = 0;
    @(negedge clk);
    op = o; dst_id = d; src_val = s; sp_cur = sp; dest_pc = t; ret_pc = n; start = 1;
    @(negedge clk);
    if (second) begin
      op = 2'b00; src_val = 32'hBB; sp_cur = 32'h90;
    end else start = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (i == 1) start = 0;
      if (done) begin
        seen = 1;
        c_sp_we = sp_we; c_rf_we = rf_we; c_pc_we = pc_we;
        c_sp = sp_new; c_rf = rf_data; c_pc = pc_new; c_stat = stat; c_id = rf_id;
      end else @(negedge clk);
    end
    start = 0;
    if (!seen) check("R9 done seen", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 mem_req", mem_req, 0);
    check("R1 done", done, 0);
    check("R1 enables", {sp_we, rf_we, pc_we}, 0);
  endtask

  task automatic t_push_pop;
    int t0 = txn, d0 = n_done;
    run_op(2'b00, 4'h0, 32'hDEADBEEF, 32'h40, 0, 0);
    check("R2 sp_new", c_sp, 32'h3C);
    check("R2 sp_we", c_sp_we, 1);
    check("R2 no rf/pc", {c_rf_we, c_pc_we}, 0);
    check("R2 memory", mem[15], 32'hDEADBEEF);
    check("R8 ok stat", c_stat, 1);
    check("R9 one txn", txn - t0, 1);
    check("R9 one done", n_done - d0, 1);
    run_op(2'b01, 4'h1, 0, 32'h3C, 0, 0);
    check("R3 rf_we", c_rf_we, 1);
    check("R3 rf_id", c_id, 1);
    check("R3 rf_data", c_rf, 32'hDEADBEEF);
    check("R3 sp_new", c_sp, 32'h40);
    check("R3 no pc", c_pc_we, 0);
  endtask

  task automatic t_call_ret;
    run_op(2'b10, 0, 0, 32'h80, 32'h200, 32'h111);
    check("R4 memory", mem[31], 32'h111);
    check("R4 sp_new", c_sp, 32'h7C);
    check("R4 pc", {c_pc_we, c_pc}, {1'b1, 32'h200});
    check("R4 no rf", c_rf_we, 0);
    run_op(2'b11, 0, 0, 32'h7C, 0, 0);
    check("R5 pc", {c_pc_we, c_pc}, {1'b1, 32'h111});
    check("R5 sp_new", c_sp, 32'h80);
  endtask

  task automatic t_pop_special;
    run_op(2'b00, 0, 32'h55, 32'h2C, 0, 0);
    run_op(2'b01, 4'h4, 0, 32'h28, 0, 0);
    check("R6 sp_new loaded", c_sp, 32'h55);
    check("R6 sp_we", c_sp_we, 1);
    check("R6 no rf", c_rf_we, 0);
    run_op(2'b01, 4'hF, 0, 32'h28, 0, 0);
    check("R7 no rf", c_rf_we, 0);
    check("R7 sp_new", c_sp, 32'h2C);
  endtask

  task automatic t_error;
    run_op(2'b00, 0, 32'h77, 32'h1000, 0, 0);
    check("R8 push stat", c_stat, 3);
    check("R8 push enables", {c_sp_we, c_rf_we, c_pc_we}, 0);
    run_op(2'b11, 0, 0, 32'h2000, 0, 0);
    check("R8 ret stat", c_stat, 3);
    check("R8 ret enables", {c_sp_we, c_rf_we, c_pc_we}, 0);
  endtask

  task automatic t_busy;
    int t0, d0;
    run_op(2'b00, 0, 32'h12, 32'h90, 0, 0);
    t0 = txn; d0 = n_done;
    run_op(2'b00, 0, 32'hAA, 32'h50, 0, 0, 1);
    repeat (6) @(negedge clk);
    check("R10 one txn", txn - t0, 1);
    check("R10 one done", n_done - d0, 1);
    check("R10 first result", c_sp, 32'h4C);
    check("R10 first memory", mem[19], 32'hAA);
    run_op(2'b01, 4'h2, 0, 32'h8C, 0, 0);
    check("R10 slot untouched", c_rf, 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_call_ret();
    t_pop_special();
    t_error();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule